// File: doc/BRIEF.md
# Background Pixel Shifter Pipeline

This block forms the background pixel of a tile-based video renderer, one pixel per cycle. Two 16-bit pattern registers hold bit-planes for two tiles. Two 8-bit attribute registers hold the matching palette bits. Each active cycle, a fine horizontal scroll value picks one bit position from all four registers. The four selected bits form a 4-bit background colour index. That index goes through two register stages, so the first pixel of a line appears on cycle 4 of the scanline.

A fetch engine outside the block supplies tile bit-planes and a 2-bit attribute. It drives them on fixed tile-boundary cycles, together with the current scanline number (signed; negative means the pre-render line) and the cycle number within the scanline. The block also gives a combinational image-start strobe. Sprite-overlap logic uses it to learn the earliest cycle on which a hit may be flagged.

Top module: `bg_pixel_pipe`

## Requirements
- R1: After reset, `pix_valid` is 0, `pix_idx` is 0 and `img_start` is 0 until a visible scanline is rendered.
- R2: `img_start` is high during cycle 2 of every visible scanline (line 0 to 239) while `render_en` is 1. It is low on every other cycle.
- R3: Shifting only happens on scanlines numbered 0 or above, at cycles 2 through 256. Cycles 0 and 1 never shift, so pixel 0 of a line is taken at stream position `fine_x` of the primed tiles.
- R4: A bit selected during cycle c is presented on `pix_idx` during cycle c+2. The first valid pixel of a visible line appears during cycle 4.
- R5: Exactly 256 consecutive valid pixels come out per visible scanline, during cycles 4 to 259.
- R6: `pix_idx` is {attr bit 1, attr bit 0, high-plane bit, low-plane bit}. Pixel p uses stream position s = p + `fine_x`. It takes tile s/8, bit 7 - (s mod 8) of each plane byte (bit 7 leftmost), and that tile's attribute.
- R7: Tile data is captured only on cycle 0 (tile 0), cycle 1 (tile 1) and cycles 9, 17, ..., 249 (tile (c+7)/8). Values on the tile inputs at any other cycle have no effect on the pixels.
- R8: On scanlines below 0 or at 240 and above, and whenever `render_en` is 0, `pix_valid` stays 0. Whenever `pix_valid` is 0, `pix_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| render_en | input | 1 | Background rendering enabled |
| line_num | input | 10 | Signed scanline number; negative is pre-render |
| cyc_num | input | 9 | Cycle number within the scanline |
| fine_x | input | 3 | Fine horizontal scroll, selects the sampled bit position |
| tile_lo | input | 8 | Low bit-plane byte of the tile being loaded |
| tile_hi | input | 8 | High bit-plane byte of the tile being loaded |
| tile_attr | input | 2 | Palette attribute of the tile being loaded |
| img_start | output | 1 | Image-start strobe for hit detection |
| pix_valid | output | 1 | Background pixel on `pix_idx` is valid |
| pix_idx | output | 4 | Background colour index |

## Verification
The bench covers all eight fine-scroll values at the tile seams. Here a design that mis-aligns the attribute latch with the pattern reload shows the wrong palette for up to seven pixels per tile. It drives junk on the tile inputs outside the capture cycles, so a reload decoded on the wrong phase corrupts whole tiles. It checks the cycle of the first valid pixel and the count of valid pixels. An extra shift at cycle 1 or a missing pipeline stage would move pixel 0 or shorten the run. Non-visible lines and a disabled line check that a leaking valid window or a pixel that is not cleared when idle shows up at the ports.

// File: rtl/bg_pipe_pkg.sv
package bg_pipe_pkg;
  // Width of the background colour index: two attribute bits, two plane bits.
  localparam int PIX_W = 4;
  // Number of bit-planes and attribute planes carried per tile.
  localparam int PLANES = 2;

  typedef logic [PIX_W-1:0] bg_pix_t;
endpackage

// File: rtl/bg_timing_ctrl.sv
// Decodes the scanline/cycle position into per-cycle enables for the
// shift bank and the pixel stage.
module bg_timing_ctrl #(
  parameter int CYC_W       = 9,
  parameter int LINE_W      = 10,
  parameter int TILE_W      = 8,
  parameter int VIS_LINES   = 240,
  parameter int FIRST_SHIFT = 2,
  parameter int LAST_SHIFT  = 256
) (
  input  logic                     render_en,
  input  logic signed [LINE_W-1:0] line_num,
  input  logic [CYC_W-1:0]         cyc_num,
  output logic                     prime_en,
  output logic                     shift_en,
  output logic                     reload_en,
  output logic                     sel_en,
  output logic                     img_start
);
  localparam int TSEL_W       = $clog2(TILE_W);
  localparam int FIRST_RELOAD = FIRST_SHIFT + TILE_W - 1;
  localparam int LAST_RELOAD  = LAST_SHIFT - TILE_W + 1;
  localparam int LAST_SEL     = LAST_SHIFT + 1;
  localparam logic [TSEL_W-1:0] RELOAD_PHASE = TSEL_W'(FIRST_RELOAD % TILE_W);

  logic              line_go;
  logic              line_vis;
  logic [LINE_W-1:0] line_u;
  logic              in_shift_win;
  logic              in_reload_win;
  logic              in_sel_win;

  always_comb begin
    line_u        = line_num;
    line_go       = render_en && !line_num[LINE_W-1];
    line_vis      = line_go && (line_u < LINE_W'(VIS_LINES));
    in_shift_win  = (cyc_num >= CYC_W'(FIRST_SHIFT)) && (cyc_num <= CYC_W'(LAST_SHIFT));
    in_reload_win = (cyc_num >= CYC_W'(FIRST_RELOAD)) && (cyc_num <= CYC_W'(LAST_RELOAD))
                    && (cyc_num[TSEL_W-1:0] == RELOAD_PHASE);
    in_sel_win    = (cyc_num >= CYC_W'(FIRST_SHIFT)) && (cyc_num <= CYC_W'(LAST_SEL));

    prime_en  = line_go && (cyc_num < CYC_W'(FIRST_SHIFT));
    shift_en  = line_go && in_shift_win;
    reload_en = line_go && in_reload_win;
    sel_en    = line_vis && in_sel_win;
    img_start = line_vis && (cyc_num == CYC_W'(FIRST_SHIFT));
  end
endmodule

// File: rtl/bg_shift_bank.sv
// Two 2-tile pattern shifters and two attribute shifters fed from a latch.
module bg_shift_bank
  import bg_pipe_pkg::*;
#(
  parameter int TILE_W = 8,
  localparam int PAT_W = 2 * TILE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prime_en,
  input  logic                          shift_en,
  input  logic                          reload_en,
  input  logic [PLANES-1:0][TILE_W-1:0] plane_in,
  input  logic [PLANES-1:0]             attr_in,
  output logic [PLANES-1:0][PAT_W-1:0]  pat_q,
  output logic [PLANES-1:0][TILE_W-1:0] attr_q
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [PAT_W-1:0]  pat_r, pat_d;
    logic [TILE_W-1:0] atr_r, atr_d;
    logic              lat_r, lat_d;
    logic              pat_ce, atr_ce, lat_ce;

    always_comb begin
      pat_ce = prime_en || shift_en || reload_en;
      pat_d  = pat_r;
      if (prime_en) begin
        // A prime step moves the pending tile up and takes a new one below.
        pat_d = {pat_r[TILE_W-1:0], plane_in[p]};
      end else begin
        if (shift_en)  pat_d = {pat_r[PAT_W-2:0], 1'b0};
        if (reload_en) pat_d[TILE_W-1:0] = plane_in[p];
      end
    end

    always_comb begin
      atr_ce = prime_en || shift_en;
      atr_d  = atr_r;
      if (prime_en)      atr_d = {TILE_W{lat_r}};
      else if (shift_en) atr_d = {atr_r[TILE_W-2:0], lat_r};
    end

    always_comb begin
      lat_ce = prime_en || reload_en;
      lat_d  = attr_in[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_r <= '0;
        atr_r <= '0;
        lat_r <= 1'b0;
      end else begin
        if (pat_ce) pat_r <= pat_d;
        if (atr_ce) atr_r <= atr_d;
        if (lat_ce) lat_r <= lat_d;
      end
    end

    assign pat_q[p]  = pat_r;
    assign attr_q[p] = atr_r;
  end
endmodule

// File: rtl/bg_pixel_stage.sv
// Fine-scroll bit selection followed by a fixed-depth output pipeline.
module bg_pixel_stage
  import bg_pipe_pkg::*;
#(
  parameter int TILE_W     = 8,
  parameter int PIPE_DEPTH = 2,
  localparam int PAT_W = 2 * TILE_W,
  localparam int FX_W  = $clog2(TILE_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_en,
  input  logic [FX_W-1:0]               fine_x,
  input  logic [PLANES-1:0][PAT_W-1:0]  pat_q,
  input  logic [PLANES-1:0][TILE_W-1:0] attr_q,
  output bg_pix_t                       pix_idx,
  output logic                          pix_valid
);
  localparam int PIDX_W = $clog2(PAT_W);
  localparam int AIDX_W = $clog2(TILE_W);

  logic [PIDX_W-1:0] pat_pos;
  logic [AIDX_W-1:0] atr_pos;
  bg_pix_t           sel_pix;
  bg_pix_t           pix_r [PIPE_DEPTH];
  logic              vld_r [PIPE_DEPTH];

  always_comb begin
    pat_pos = PIDX_W'(PAT_W - 1) - PIDX_W'(fine_x);
    atr_pos = AIDX_W'(TILE_W - 1) - AIDX_W'(fine_x);
    sel_pix = '0;
    if (sel_en) begin
      sel_pix = {attr_q[1][atr_pos], attr_q[0][atr_pos], pat_q[1][pat_pos], pat_q[0][pat_pos]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < PIPE_DEPTH; s++) begin
        pix_r[s] <= '0;
        vld_r[s] <= 1'b0;
      end
    end else begin
      pix_r[0] <= sel_pix;
      vld_r[0] <= sel_en;
      for (int s = 1; s < PIPE_DEPTH; s++) begin
        pix_r[s] <= pix_r[s-1];
        vld_r[s] <= vld_r[s-1];
      end
    end
  end

  assign pix_idx   = pix_r[PIPE_DEPTH-1];
  assign pix_valid = vld_r[PIPE_DEPTH-1];
endmodule

// File: rtl/bg_pixel_pipe.sv
// Top level of the background pixel path.
module bg_pixel_pipe
  import bg_pipe_pkg::*;
#(
  parameter int CYC_W       = 9,
  parameter int LINE_W      = 10,
  parameter int TILE_W      = 8,
  parameter int VIS_LINES   = 240,
  parameter int FIRST_SHIFT = 2,
  parameter int LAST_SHIFT  = 256,
  parameter int PIPE_DEPTH  = 2,
  localparam int FX_W  = $clog2(TILE_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     render_en,
  input  logic signed [LINE_W-1:0] line_num,
  input  logic [CYC_W-1:0]         cyc_num,
  input  logic [FX_W-1:0]          fine_x,
  input  logic [TILE_W-1:0]        tile_lo,
  input  logic [TILE_W-1:0]        tile_hi,
  input  logic [1:0]               tile_attr,
  output logic                     img_start,
  output logic                     pix_valid,
  output logic [PIX_W-1:0]         pix_idx
);
  localparam int PAT_W = 2 * TILE_W;

  logic                          rst_meta_n;
  logic                          rst_sync_n;
  logic                          prime_en;
  logic                          shift_en;
  logic                          reload_en;
  logic                          sel_en;
  logic [PLANES-1:0][TILE_W-1:0] plane_in;
  logic [PLANES-1:0][PAT_W-1:0]  pat_q;
  logic [PLANES-1:0][TILE_W-1:0] attr_q;
  bg_pix_t                       pix_out;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign plane_in = {tile_hi, tile_lo};

  bg_timing_ctrl #(
    .CYC_W(CYC_W), .LINE_W(LINE_W), .TILE_W(TILE_W), .VIS_LINES(VIS_LINES),
    .FIRST_SHIFT(FIRST_SHIFT), .LAST_SHIFT(LAST_SHIFT)
  ) u_timing (
    .render_en(render_en), .line_num(line_num), .cyc_num(cyc_num),
    .prime_en(prime_en), .shift_en(shift_en), .reload_en(reload_en),
    .sel_en(sel_en), .img_start(img_start)
  );

  bg_shift_bank #(.TILE_W(TILE_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .prime_en(prime_en), .shift_en(shift_en),
    .reload_en(reload_en), .plane_in(plane_in), .attr_in(tile_attr),
    .pat_q(pat_q), .attr_q(attr_q)
  );

  bg_pixel_stage #(.TILE_W(TILE_W), .PIPE_DEPTH(PIPE_DEPTH)) u_stage (
    .clk(clk), .rst_n(rst_sync_n), .sel_en(sel_en), .fine_x(fine_x),
    .pat_q(pat_q), .attr_q(attr_q), .pix_idx(pix_out), .pix_valid(pix_valid)
  );

  assign pix_idx = pix_out;
endmodule

// File: rtl/bg_pipe_chk.sv
// Property checker attached to the top through bind.
module bg_pipe_chk #(
  parameter int CYC_W       = 9,
  parameter int TILE_W      = 8,
  parameter int FIRST_SHIFT = 2,
  parameter int LAST_SHIFT  = 256,
  localparam int PAT_W   = 2 * TILE_W,
  localparam int MAX_RUN = LAST_SHIFT
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CYC_W-1:0]        cyc_num,
  input logic                    img_start,
  input logic                    pix_valid,
  input logic [3:0]              pix_idx,
  input logic                    prime_en,
  input logic                    shift_en,
  input logic                    reload_en,
  input logic [1:0][PAT_W-1:0]   pat_q,
  input logic [1:0][TILE_W-1:0]  attr_q
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (pix_valid) run_cnt <= run_cnt + 16'd1;
    else                run_cnt <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> (!pix_valid && pix_idx == 4'd0));

  p_strobe_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    img_start |-> ##2 pix_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!prime_en && !shift_en && !reload_en) |=> ($stable(pat_q) && $stable(attr_q)));

  p_shift_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !prime_en && !reload_en) |=>
      (pat_q[0] == ($past(pat_q[0]) << 1) && pat_q[1] == ($past(pat_q[1]) << 1)));

  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ($past(cyc_num, 2) >= CYC_W'(FIRST_SHIFT) && $past(cyc_num, 2) <= CYC_W'(LAST_SHIFT + 1)));

  p_run_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 16'(MAX_RUN));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_idx == 4'd0));
endmodule

bind bg_pixel_pipe bg_pipe_chk #(
  .CYC_W(CYC_W), .TILE_W(TILE_W), .FIRST_SHIFT(FIRST_SHIFT), .LAST_SHIFT(LAST_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cyc_num(cyc_num), .img_start(img_start),
  .pix_valid(pix_valid), .pix_idx(pix_idx), .prime_en(prime_en),
  .shift_en(shift_en), .reload_en(reload_en), .pat_q(pat_q), .attr_q(attr_q)
);

// File: tb/bg_pixel_pipe_bench.sv
module bg_pixel_pipe_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              render_en;
  logic signed [9:0] line_num;
  logic [8:0]        cyc_num;
  logic [2:0]        fine_x;
  logic [7:0]        tile_lo, tile_hi;
  logic [1:0]        tile_attr;
  logic              img_start, pix_valid;
  logic [3:0]        pix_idx;

  int errs = 0;
  int checks = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  logic [3:0] exp_q [$];
  logic [7:0] t_lo [0:33];
  logic [7:0] t_hi [0:33];
  logic [1:0] t_at [0:33];

  int valid_cnt, first_valid, strobe_cnt, strobe_cyc, pix_no;

  always #2 clk = ~clk;

  bg_pixel_pipe u_bg_pixel_pipe (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .line_num(line_num),
    .cyc_num(cyc_num), .fine_x(fine_x), .tile_lo(tile_lo), .tile_hi(tile_hi),
    .tile_attr(tile_attr), .img_start(img_start), .pix_valid(pix_valid), .pix_idx(pix_idx)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hval(input int a);
    return 8'((a * 73 + 29) ^ (a >>> 2));
  endfunction

  // Monitor: pops expected pixels and compares them as they appear.
  always @(negedge clk) begin
    if (mon_on) begin
      if (img_start) begin
        strobe_cnt++;
        strobe_cyc = int'(cyc_num);
      end
      if (pix_valid) begin
        if (valid_cnt == 0) first_valid = int'(cyc_num);
        valid_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected valid pixel", int'(pix_idx), 0);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(pix_idx == e, "R6", $sformatf("pixel %0d value", pix_no), int'(pix_idx), int'(e));
          pix_no++;
        end
      end else begin
        chk(pix_idx == 4'd0, "R8", "idle pixel index", int'(pix_idx), 0);
      end
    end
  end

  // Driver: one full scanline with its tile stream and expected pixels.
  task automatic run_line(input int ln, input int fx, input bit en, input int seed);
    bit vis;
    for (int k = 0; k < 34; k++) begin
      if (seed < 0) begin
        t_lo[k] = 8'hF0;
        t_hi[k] = 8'h3C ^ 8'(k);
        t_at[k] = 2'(k);
      end else begin
        t_lo[k] = hval(seed + k);
        t_hi[k] = hval(seed * 7 + k * 3 + 1);
        t_at[k] = 2'(hval(seed + 5 * k) >> 3);
      end
    end
    vis = en && ln >= 0 && ln < 240;
    if (vis) begin
      for (int p = 0; p < 256; p++) begin
        int s, t, b;
        s = p + fx;
        t = s / 8;
        b = 7 - (s % 8);
        exp_q.push_back({t_at[t], t_hi[t][b], t_lo[t][b]});
      end
    end
    valid_cnt = 0; first_valid = -1; strobe_cnt = 0; strobe_cyc = -1; pix_no = 0;
    for (int c = 0; c < 341; c++) begin
      int k;
      @(posedge clk);
      #1;
      cyc_num   = 9'(c);
      line_num  = 10'(ln);
      fine_x    = 3'(fx);
      render_en = en;
      k = -1;
      if (c == 0) k = 0;
      else if (c == 1) k = 1;
      else if (c % 8 == 1 && c >= 9 && c <= 249) k = (c + 7) / 8;
      if (k >= 0) begin
        tile_lo = t_lo[k]; tile_hi = t_hi[k]; tile_attr = t_at[k];
      end else begin
        // R7: junk off the capture cycles must not reach any pixel.
        tile_lo = 8'hA5 ^ 8'(c); tile_hi = 8'h5A + 8'(c); tile_attr = 2'(c >> 1);
      end
    end
    @(posedge clk);
    #1;
    chk(valid_cnt == (vis ? 256 : 0), "R5", $sformatf("valid count line %0d", ln), valid_cnt, vis ? 256 : 0);
    chk(exp_q.size() == 0, "R5", "pixels left unconsumed", exp_q.size(), 0);
    exp_q.delete();
    if (vis) begin
      chk(first_valid == 4, "R4", $sformatf("first valid cycle line %0d", ln), first_valid, 4);
      chk(strobe_cnt == 1 && strobe_cyc == 2, "R2", "image start cycle", strobe_cyc, 2);
    end else begin
      chk(strobe_cnt == 0, "R2", $sformatf("strobe on hidden line %0d", ln), strobe_cnt, 0);
      chk(valid_cnt == 0, "R8", $sformatf("valid on hidden line %0d", ln), valid_cnt, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; render_en = 1'b0; line_num = -10'sd1; cyc_num = '0; fine_x = '0;
    tile_lo = '0; tile_hi = '0; tile_attr = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pix_valid == 1'b0, "R1", "valid after reset", int'(pix_valid), 0);
    chk(pix_idx == 4'd0, "R1", "pixel after reset", int'(pix_idx), 0);
    chk(img_start == 1'b0, "R1", "strobe after reset", int'(img_start), 0);
    mon_on = 1'b1;
    // R3 R6 R7: every fine-scroll value across visible lines.
    run_line(0, 0, 1'b1, 11);
    run_line(5, 3, 1'b1, 40);
    run_line(6, 1, 1'b1, -1);
    run_line(100, 7, 1'b1, 77);
    run_line(101, 2, 1'b1, 3);
    run_line(102, 4, 1'b1, 19);
    run_line(103, 6, 1'b1, -1);
    run_line(239, 5, 1'b1, 91);
    // R8: hidden lines and rendering disabled.
    run_line(240, 2, 1'b1, 8);
    run_line(-1, 0, 1'b1, 9);
    run_line(10, 4, 1'b0, 12);
    // Recovery after a disabled line.
    run_line(11, 1, 1'b1, 55);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule